// File: doc/BRIEF.md
# Accumulator command mailbox

This block is the register window a host uses to set up one channel of a queue-monitoring accumulator. The window holds five 32-bit words. Four of them are parameter words: the queue enable mask, the list base address, the queue selection word and the control word. The fifth, at word address 0, is the command word. The host fills the parameter words first, from the highest address down. It then writes the command word last, and that write starts the operation.

Once a command is accepted, the block shows it as busy in bits 15:8 of the command word. It decodes the parameter words into separate fields and offers them, together with the channel number and command code, on a valid/ready interface to the channel configuration table. The block holds the offer, with every field stable, until the table raises ready. After the transfer the block waits for a completion pulse from the table, which carries a return code. On that pulse the return code goes into bits 31:24 of the command word and the command byte clears in the same cycle. The host polls bits 15:8 for zero, both before it issues a command and to detect that the command has finished.

A command that names a channel the table does not have is never offered to the table. It completes on its own with an error code.

Top module: `acc_cmd_mailbox`

## Requirements
- R1: After reset, all five words read as zero and `cfg_valid` is low.
- R2: The block accepts a command when it is idle and the host writes word 0 with a nonzero code in bits 15:8.
  - From the next cycle, bits 15:8 read back that code and bits 7:0 read back the channel number.
  - Bits 31:24 read zero until the command completes.
  - A write to word 0 with a code of zero is ignored.
- R3: When `done_valid` arrives while a command is waiting for completion, the next read of word 0 shows `done_code` in bits 31:24 and zero in bits 15:8. The return code and the clearing of the command byte take effect in the same cycle. The channel number in bits 7:0 is kept, and bits 23:16 read zero.
- R4: While bits 15:8 of word 0 are nonzero, host writes to any word, including word 0, are ignored.
- R5: A command whose channel number is NUM_CHAN or more (48 by default) is never offered on `cfg_valid`. It completes in the cycle after it is issued, with the return code ERR_CODE (3 by default), and leaves the parameter words unchanged.
- R6: The offered fields are taken from these bit positions:
  - Word 4: timer load in 15:0, interrupt mode in 17:16, list entry size in 19:18, list count mode in 20, multi-queue mode in 21.
  - Word 3: queue number in 15:0, maximum page entries in 31:16.
  - Word 2: list base address.
  - Word 1: queue enable mask.
  - Command word: channel in 7:0, code in 15:8.
- R7: While `cfg_valid` is high and `cfg_ready` is low, `cfg_valid` stays high and every offered field stays stable. Each accepted command transfers exactly once, and `cfg_valid` is low after the transfer.
- R8: A `done_valid` pulse that arrives while no command is waiting for completion has no effect on word 0.
- R9: Word addresses are fixed as follows: 0 command, 1 queue enable mask, 2 list base, 3 queue selection, 4 control. Any other address reads zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for the addressed word (combinational) |
| cfg_valid | output | 1 | Decoded command offered to the table |
| cfg_ready | input | 1 | Table accepts the offer |
| cfg_chan | output | 8 | Channel number |
| cfg_op | output | 8 | Command code |
| cfg_timer | output | 16 | Timer load count |
| cfg_int_mode | output | 2 | Interrupt mode |
| cfg_entry_size | output | 2 | List entry size |
| cfg_cnt_mode | output | 1 | List count mode |
| cfg_multi_q | output | 1 | Multi-queue mode |
| cfg_queue | output | 16 | Monitored queue number |
| cfg_max_entries | output | 16 | Maximum page entries |
| cfg_list_base | output | 32 | List base address |
| cfg_q_mask | output | 32 | Queue enable mask |
| done_valid | input | 1 | Completion pulse from the table |
| done_code | input | 8 | Return code carried with the completion pulse |

## Verification
The bench builds the block with its defaults, NUM_CHAN of 48 and ERR_CODE of 3. With these values, channels 47, 48 and 255 land on both sides of the channel limit, so the reject path and the last legal channel are both exercised. The vectors mix table return codes other than 1 and stalls of zero to two cycles on `cfg_ready`, which covers back-pressure on the offer. Between offer and completion, the bench writes to a parameter word and to the command word, then reads both back to show the lock.

// File: rtl/acc_mbx_pkg.sv
package acc_mbx_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 3;
  localparam int NUM_PARAM = 4;
  localparam int NUM_WORDS = NUM_PARAM + 1;

  localparam logic [ADDR_W-1:0] A_CMD   = 3'd0;
  localparam logic [ADDR_W-1:0] A_QMASK = 3'd1;
  localparam logic [ADDR_W-1:0] A_LBASE = 3'd2;
  localparam logic [ADDR_W-1:0] A_QSEL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_OFFER  = 2'd1,
    ST_WAIT   = 2'd2,
    ST_REJECT = 2'd3
  } mbx_state_e;

  typedef struct packed {
    logic [15:0] timer;
    logic [1:0]  int_mode;
    logic [1:0]  entry_size;
    logic        cnt_mode;
    logic        multi_q;
    logic [15:0] queue;
    logic [15:0] max_entries;
    logic [31:0] list_base;
    logic [31:0] q_mask;
  } chan_cfg_t;
endpackage

// File: rtl/acc_mbx_params.sv
module acc_mbx_params
  import acc_mbx_pkg::*;
#(
  parameter int NP = NUM_PARAM
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 lock,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    wdata,
  output logic [NP-1:0][WORD_W-1:0] words
);
  for (genvar gi = 0; gi < NP; gi++) begin : g_word
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(gi + 1);
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (wr_en && !lock && addr == MY_ADDR) begin
        word_q <= wdata;
      end
    end
    assign words[gi] = word_q;
  end
endmodule

// File: rtl/acc_mbx_unpack.sv
module acc_mbx_unpack
  import acc_mbx_pkg::*;
(
  input  logic [NUM_PARAM-1:0][WORD_W-1:0] words,
  output chan_cfg_t                       cfg
);
  logic [WORD_W-1:0] ctrl_w, qsel_w;

  always_comb begin
    ctrl_w          = words[A_CTRL - 1];
    qsel_w          = words[A_QSEL - 1];
    cfg.timer       = ctrl_w[15:0];
    cfg.int_mode    = ctrl_w[17:16];
    cfg.entry_size  = ctrl_w[19:18];
    cfg.cnt_mode    = ctrl_w[20];
    cfg.multi_q     = ctrl_w[21];
    cfg.queue       = qsel_w[15:0];
    cfg.max_entries = qsel_w[31:16];
    cfg.list_base   = words[A_LBASE - 1];
    cfg.q_mask      = words[A_QMASK - 1];
  end
endmodule

// File: rtl/acc_mbx_cmd_fsm.sv
module acc_mbx_cmd_fsm
  import acc_mbx_pkg::*;
#(
  parameter int         NUM_CHAN = 48,
  parameter logic [7:0] ERR_CODE = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              cfg_ready,
  input  logic              done_valid,
  input  logic [7:0]        done_code,
  output logic              busy,
  output logic              cfg_valid,
  output logic [7:0]        chan,
  output logic [7:0]        op,
  output logic [WORD_W-1:0] cmd_word
);
  localparam logic [8:0] CHAN_LIMIT = 9'(NUM_CHAN);

  mbx_state_e state_q;
  logic [7:0] ret_q, op_q, chan_q;
  logic       new_ok;

  assign new_ok = ({1'b0, wdata[7:0]} < CHAN_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ret_q   <= '0;
      op_q    <= '0;
      chan_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_wr && wdata[15:8] != 8'h00) begin
            op_q    <= wdata[15:8];
            chan_q  <= wdata[7:0];
            ret_q   <= '0;
            state_q <= new_ok ? ST_OFFER : ST_REJECT;
          end
        end
        ST_OFFER: begin
          if (cfg_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (done_valid) begin
            ret_q   <= done_code;
            op_q    <= '0;
            state_q <= ST_IDLE;
          end
        end
        ST_REJECT: begin
          ret_q   <= ERR_CODE;
          op_q    <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign cfg_valid = (state_q == ST_OFFER);
  assign chan      = chan_q;
  assign op        = op_q;
  assign cmd_word  = {ret_q, 8'h00, op_q, chan_q};
endmodule

// File: rtl/acc_cmd_mailbox.sv
module acc_cmd_mailbox
  import acc_mbx_pkg::*;
#(
  parameter int         NUM_CHAN = 48,
  parameter logic [7:0] ERR_CODE = 8'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cfg_valid,
  input  logic        cfg_ready,
  output logic [7:0]  cfg_chan,
  output logic [7:0]  cfg_op,
  output logic [15:0] cfg_timer,
  output logic [1:0]  cfg_int_mode,
  output logic [1:0]  cfg_entry_size,
  output logic        cfg_cnt_mode,
  output logic        cfg_multi_q,
  output logic [15:0] cfg_queue,
  output logic [15:0] cfg_max_entries,
  output logic [31:0] cfg_list_base,
  output logic [31:0] cfg_q_mask,
  input  logic        done_valid,
  input  logic [7:0]  done_code
);
  logic [NUM_PARAM-1:0][WORD_W-1:0] param_words;
  logic [WORD_W-1:0] cmd_word;
  logic              busy;
  chan_cfg_t         cfg;

  acc_mbx_params #(.NP(NUM_PARAM)) u_params (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .lock  (busy),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .words (param_words)
  );

  acc_mbx_cmd_fsm #(.NUM_CHAN(NUM_CHAN), .ERR_CODE(ERR_CODE)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (reg_wr && reg_addr == A_CMD),
    .wdata      (reg_wdata),
    .cfg_ready  (cfg_ready),
    .done_valid (done_valid),
    .done_code  (done_code),
    .busy       (busy),
    .cfg_valid  (cfg_valid),
    .chan       (cfg_chan),
    .op         (cfg_op),
    .cmd_word   (cmd_word)
  );

  acc_mbx_unpack u_unpack (
    .words (param_words),
    .cfg   (cfg)
  );

  assign cfg_timer       = cfg.timer;
  assign cfg_int_mode    = cfg.int_mode;
  assign cfg_entry_size  = cfg.entry_size;
  assign cfg_cnt_mode    = cfg.cnt_mode;
  assign cfg_multi_q     = cfg.multi_q;
  assign cfg_queue       = cfg.queue;
  assign cfg_max_entries = cfg.max_entries;
  assign cfg_list_base   = cfg.list_base;
  assign cfg_q_mask      = cfg.q_mask;

  always_comb begin
    if (reg_addr == A_CMD) begin
      reg_rdata = cmd_word;
    end else if (reg_addr < ADDR_W'(NUM_WORDS)) begin
      reg_rdata = param_words[reg_addr - 3'd1];
    end else begin
      reg_rdata = '0;
    end
  end
endmodule

// File: rtl/acc_cmd_mailbox_chk.sv
module acc_cmd_mailbox_chk #(
  parameter int NUM_CHAN = 48
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] cmd_word,
  input logic        cfg_valid,
  input logic        cfg_ready,
  input logic [7:0]  cfg_chan,
  input logic [31:0] cfg_list_base,
  input logic [31:0] cfg_q_mask,
  input logic [15:0] cfg_timer,
  input logic        done_valid,
  input logic [7:0]  done_code
);
  localparam logic [8:0] LIM = 9'(NUM_CHAN);

  logic idle, busy, waiting;
  assign idle    = (cmd_word[15:8] == 8'h00);
  assign busy    = !idle;
  assign waiting = busy && !cfg_valid && ({1'b0, cmd_word[7:0]} < LIM);

  AST_ISSUE_SHOWS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && reg_wr && reg_addr == 3'd0 && reg_wdata[15:8] != 8'h00)
      |=> (cmd_word[15:8] == $past(reg_wdata[15:8]) && cmd_word[31:24] == 8'h00)); // R2

  AST_DONE_WRITES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && done_valid)
      |=> (cmd_word[15:8] == 8'h00 && cmd_word[31:24] == $past(done_code))); // R3

  AST_BUSY_LOCKS_PARAMS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cfg_list_base) && $stable(cfg_q_mask) && $stable(cfg_timer))); // R4

  AST_NO_OFFER_BAD_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> ({1'b0, cfg_chan} < LIM)); // R5

  AST_OFFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_chan) && $stable(cfg_list_base))); // R7

  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && done_valid && !(reg_wr && reg_addr == 3'd0)) |=> $stable(cmd_word)); // R8
endmodule

bind acc_cmd_mailbox acc_cmd_mailbox_chk #(.NUM_CHAN(NUM_CHAN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .cmd_word      (cmd_word),
  .cfg_valid     (cfg_valid),
  .cfg_ready     (cfg_ready),
  .cfg_chan      (cfg_chan),
  .cfg_list_base (cfg_list_base),
  .cfg_q_mask    (cfg_q_mask),
  .cfg_timer     (cfg_timer),
  .done_valid    (done_valid),
  .done_code     (done_code)
);

// File: tb/acc_cmd_mailbox_test.sv
module acc_cmd_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cfg_valid, cfg_ready = 1'b0;
  logic [7:0]  cfg_chan, cfg_op;
  logic [15:0] cfg_timer, cfg_queue, cfg_max_entries;
  logic [1:0]  cfg_int_mode, cfg_entry_size;
  logic        cfg_cnt_mode, cfg_multi_q;
  logic [31:0] cfg_list_base, cfg_q_mask;
  logic        done_valid = 1'b0;
  logic [7:0]  done_code = '0;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  acc_cmd_mailbox uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_chan(cfg_chan), .cfg_op(cfg_op),
    .cfg_timer(cfg_timer), .cfg_int_mode(cfg_int_mode),
    .cfg_entry_size(cfg_entry_size), .cfg_cnt_mode(cfg_cnt_mode),
    .cfg_multi_q(cfg_multi_q), .cfg_queue(cfg_queue),
    .cfg_max_entries(cfg_max_entries), .cfg_list_base(cfg_list_base),
    .cfg_q_mask(cfg_q_mask), .done_valid(done_valid), .done_code(done_code)
  );

  // vector: channel, code, table return code, ready stall cycles, expected return
  localparam logic [39:0] VEC [0:5] = '{
    {8'd0,   8'h81, 8'h01, 8'd0, 8'h01},
    {8'd47,  8'h81, 8'h01, 8'd1, 8'h01},
    {8'd5,   8'h82, 8'h07, 8'd2, 8'h07},
    {8'd48,  8'h81, 8'h01, 8'd0, 8'h03},
    {8'd255, 8'h81, 8'h01, 8'd0, 8'h03},
    {8'd31,  8'h81, 8'h01, 8'd1, 8'h01}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk(d == 32'h0, "R1", d, 32'h0);
    end
    chk(cfg_valid == 1'b0, "R1", {31'b0, cfg_valid}, 32'h0);

    // R9 address map and unused address
    wr(3'd1, 32'h1111_0001); wr(3'd2, 32'h2222_0002);
    wr(3'd3, 32'h3333_0003); wr(3'd4, 32'h0004_0004);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); chk(d == 32'h0, "R9", d, 32'h0);
    rd(3'd1, d); chk(d == 32'h1111_0001, "R9", d, 32'h1111_0001);
    rd(3'd3, d); chk(d == 32'h3333_0003, "R9", d, 32'h3333_0003);
    chk(cfg_q_mask == 32'h1111_0001, "R9", cfg_q_mask, 32'h1111_0001);

    // R2 zero code ignored
    wr(3'd0, 32'h0000_0002);
    rd(3'd0, d); chk(d == 32'h0, "R2", d, 32'h0);
    chk(cfg_valid == 1'b0, "R2", {31'b0, cfg_valid}, 32'h0);

    // R8 stray completion while idle
    done_valid = 1'b1; done_code = 8'h55;
    @(negedge clk);
    done_valid = 1'b0;
    rd(3'd0, d); chk(d == 32'h0, "R8", d, 32'h0);

    for (int i = 0; i < 6; i++) begin
      logic [7:0] ch, op, tc, st, er;
      logic [31:0] ctrl, qsel, lbase, mask;
      {ch, op, tc, st, er} = VEC[i];
      ctrl  = {10'b0, 6'(i * 11 + 5), 16'(i * 257 + 3)};
      qsel  = {16'(64 + i), 16'(i * 3 + 700)};
      lbase = 32'h8000_0000 + 32'(i) * 32'h100;
      mask  = 32'hF0F0_0000 ^ 32'(i);
      wr(3'd4, ctrl); wr(3'd3, qsel); wr(3'd2, lbase); wr(3'd1, mask);
      wr(3'd0, {16'h0, op, ch});
      rd(3'd0, d);
      chk(d[15:8] == op && d[31:24] == 8'h0 && d[7:0] == ch, "R2", d, {16'h0, op, ch});
      if (ch < 8'd48) begin
        chk(cfg_valid == 1'b1, "R7", {31'b0, cfg_valid}, 32'h1);
        chk(cfg_chan == ch && cfg_op == op, "R6", {16'h0, cfg_op, cfg_chan}, {16'h0, op, ch});
        chk(cfg_timer == ctrl[15:0] && cfg_int_mode == ctrl[17:16] &&
            cfg_entry_size == ctrl[19:18] && cfg_cnt_mode == ctrl[20] &&
            cfg_multi_q == ctrl[21], "R6",
            {10'b0, cfg_multi_q, cfg_cnt_mode, cfg_entry_size, cfg_int_mode, cfg_timer}, ctrl);
        chk(cfg_queue == qsel[15:0] && cfg_max_entries == qsel[31:16], "R6",
            {cfg_max_entries, cfg_queue}, qsel);
        chk(cfg_list_base == lbase && cfg_q_mask == mask, "R6", cfg_list_base, lbase);
        for (int s = 0; s < int'(st); s++) begin
          @(negedge clk);
          chk(cfg_valid == 1'b1 && cfg_chan == ch, "R7", {23'b0, cfg_valid, cfg_chan}, {23'b0, 1'b1, ch});
        end
        cfg_ready = 1'b1;
        @(negedge clk);
        cfg_ready = 1'b0;
        chk(cfg_valid == 1'b0, "R7", {31'b0, cfg_valid}, 32'h0);
        wr(3'd2, ~lbase);
        wr(3'd0, 32'h0000_8103);
        rd(3'd0, d);
        chk(d == {16'h0, op, ch}, "R4", d, {16'h0, op, ch});
        done_valid = 1'b1; done_code = tc;
        @(negedge clk);
        done_valid = 1'b0;
        rd(3'd0, d);
        chk(d == {er, 16'h0, ch}, "R3", d, {er, 16'h0, ch});
        rd(3'd2, d);
        chk(d == lbase, "R4", d, lbase);
      end else begin
        chk(cfg_valid == 1'b0, "R5", {31'b0, cfg_valid}, 32'h0);
        @(negedge clk);
        rd(3'd0, d);
        chk(d == {er, 16'h0, ch}, "R5", d, {er, 16'h0, ch});
        rd(3'd2, d);
        chk(d == lbase, "R5", d, lbase);
      end
    end

    // R8 completion after finish ignored
    done_valid = 1'b1; done_code = 8'hAA;
    @(negedge clk);
    done_valid = 1'b0;
    rd(3'd0, d);
    chk(d == {8'h01, 16'h0, 8'd31}, "R8", d, {8'h01, 16'h0, 8'd31});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule